// File: doc/BRIEF.md
# Row-Parallel Matrix Multiply-Add Engine

The engine evaluates R = A·B + C for a signed fixed-point A of m×n, B of n×p and C of m×p. The dimensions are given at run time. NPE identical lanes work together, and each lane owns one row of the current row group. Row group g covers rows g·NPE through g·NPE+NPE−1, and lane q computes row g·NPE+q.

For each column j of a group, every lane clears its accumulator and takes n products. Lane q reads A from its own bank. All lanes share a single broadcast read of B. The lane then adds its C entry once, after the last product, and presents the finished row-group slice of R on a parallel result port with one valid flag per lane.

The groups and columns are visited in a fixed order, so a downstream consumer can rebuild R from the order in which results arrive.

A start pulse loads the dimensions. A one-cycle done pulse follows the last result. Memories are external and have a read latency of one cycle.

Top module: `mma_row_engine`

## Requirements
- R1: After reset, busy_o, done_o, mac_rd_o, c_rd_o and every bit of res_valid_o are 0.
- R2: Each valid lane result equals sum over k in [0,n) of A[row][k]·B[k][j], plus C[row][j]. Operands are signed two's complement of DW bits. The result is signed and ACC_W = 2·DW + clog2(N_MAX) + 1 bits wide.
- R3: Results are emitted once per (group, column) pair. Groups come in increasing order and, inside a group, column j runs from 0 to p−1. res_row_o carries g·NPE and res_col_o carries j. Exactly ceil(m/NPE)·p result beats occur per job.
- R4: The accumulator restarts from zero for every (group, column) pair. The first result appears n+2 cycles after the first cycle with busy_o high, and later results follow every n+1 cycles.
- R5: Lane q is flagged valid only when g·NPE+q < m. Lanes beyond m are never flagged.
- R6: The memory read port works as follows.
  - On a cycle with mac_rd_o, bank q must return A[rd_grp_o·NPE+q][rd_k_o] and the broadcast port must return B[rd_k_o][rd_j_o], both one cycle later.
  - On a cycle with c_rd_o, bank q must return C[rd_grp_o·NPE+q][rd_j_o] one cycle later.
  - mac_rd_o and c_rd_o are never high together, and are only high while busy_o is high.
- R7: done_o is high for exactly one cycle, in the cycle after the final result beat. busy_o is low in that cycle.
- R8: start_i is ignored while busy_o is high. The running job's dimensions and results are unchanged, and no extra job follows.
- R9: start_i is ignored when m, n or p is zero or exceeds M_MAX, N_MAX or P_MAX respectively.
- R10: When m ≤ NPE, one group covers all rows and done_o rises exactly p·(n+1)+2 cycles after the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a job with the given dimensions |
| m_i | input | clog2(M_MAX+1) | Row count of A and C |
| n_i | input | clog2(N_MAX+1) | Inner dimension |
| p_i | input | clog2(P_MAX+1) | Column count of B and C |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mac_rd_o | output | 1 | Read A banks and broadcast B |
| c_rd_o | output | 1 | Read C banks |
| rd_grp_o | output | GW | Row group address shared by all banks |
| rd_k_o | output | KW | Inner index address |
| rd_j_o | output | JW | Column address |
| a_data_i | input | NPE·DW | A bank read data, lane q at bits q·DW |
| b_data_i | input | DW | Broadcast B read data |
| c_data_i | input | NPE·DW | C bank read data, lane q at bits q·DW |
| res_valid_o | output | NPE | Per-lane result valid |
| res_row_o | output | clog2(M_MAX+1) | Row index of lane 0 |
| res_col_o | output | JW | Column index of the beat |
| res_data_o | output | NPE·ACC_W | Results, lane q at bits q·ACC_W |

## Verification
The following properties are checked on every cycle:
- the done pulse is single-cycle, and busy_o is low when it fires;
- read strobes are exclusive and occur only while busy;
- valid lanes are a contiguous run from lane 0 whose length matches the rows left below m;
- the column stays below p;
- the latched dimensions hold for the whole job.

Only the directed scenarios can show the numeric results. The same holds for the emission order and exact beat timing, the cycle count of single-group jobs, and the fact that starts during a job or with illegal dimensions start nothing. The scenarios cover sign extremes, a partial last group and full-size matrices.

// File: rtl/mma_pkg.sv
package mma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } mma_state_e;

  function automatic int clog1(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/mma_seq.sv
module mma_seq
  import mma_pkg::*;
#(
  parameter int NPE   = 4,
  parameter int M_MAX = 10,
  parameter int N_MAX = 8,
  parameter int P_MAX = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [$clog2(M_MAX+1)-1:0]     m_i,
  input  logic [$clog2(N_MAX+1)-1:0]     n_i,
  input  logic [$clog2(P_MAX+1)-1:0]     p_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           mac_rd_o,
  output logic                           c_rd_o,
  output logic [clog1((M_MAX+NPE-1)/NPE)-1:0] rd_grp_o,
  output logic [clog1(N_MAX)-1:0]        rd_k_o,
  output logic [clog1(P_MAX)-1:0]        rd_j_o,
  output logic                           op_mac_o,
  output logic                           op_first_o,
  output logic                           op_addc_o,
  output logic [clog1((M_MAX+NPE-1)/NPE)-1:0] op_grp_o,
  output logic [clog1(P_MAX)-1:0]        op_j_o,
  output logic [$clog2(M_MAX+1)-1:0]     m_cur_o,
  output logic [$clog2(P_MAX+1)-1:0]     p_cur_o
);

  localparam int MW = $clog2(M_MAX + 1);
  localparam int NW = $clog2(N_MAX + 1);
  localparam int PW = $clog2(P_MAX + 1);
  localparam int GW = clog1((M_MAX + NPE - 1) / NPE);
  localparam int KW = clog1(N_MAX);
  localparam int JW = clog1(P_MAX);

  mma_state_e      state_q;
  logic [MW-1:0]   m_q;
  logic [NW-1:0]   n_q;
  logic [PW-1:0]   p_q;
  logic [GW-1:0]   glast_q, grp_q;
  logic [KW-1:0]   k_q;
  logic [JW-1:0]   j_q;
  logic            cph_q;
  logic            op1_last_q, op2_last_q, done_q;
  logic            dims_ok, k_last, j_last, g_last;

  assign dims_ok = (m_i != '0) && (n_i != '0) && (p_i != '0) &&
                   (int'(m_i) <= M_MAX) && (int'(n_i) <= N_MAX) &&
                   (int'(p_i) <= P_MAX);
  assign k_last  = int'(k_q) == int'(n_q) - 1;
  assign j_last  = int'(j_q) == int'(p_q) - 1;
  assign g_last  = grp_q == glast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      m_q        <= '0;
      n_q        <= '0;
      p_q        <= '0;
      glast_q    <= '0;
      grp_q      <= '0;
      k_q        <= '0;
      j_q        <= '0;
      cph_q      <= 1'b0;
      op_mac_o   <= 1'b0;
      op_first_o <= 1'b0;
      op_addc_o  <= 1'b0;
      op_grp_o   <= '0;
      op_j_o     <= '0;
      op1_last_q <= 1'b0;
      op2_last_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      op_mac_o   <= 1'b0;
      op_addc_o  <= 1'b0;
      op1_last_q <= 1'b0;
      op2_last_q <= op_addc_o & op1_last_q;
      done_q     <= op2_last_q;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && dims_ok) begin
            m_q     <= m_i;
            n_q     <= n_i;
            p_q     <= p_i;
            glast_q <= GW'((int'(m_i) + NPE - 1) / NPE - 1);
            grp_q   <= '0;
            k_q     <= '0;
            j_q     <= '0;
            cph_q   <= 1'b0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          op_grp_o <= grp_q;
          op_j_o   <= j_q;
          if (!cph_q) begin
            op_mac_o   <= 1'b1;
            op_first_o <= (k_q == '0);
            if (k_last) cph_q <= 1'b1;
            else        k_q   <= k_q + 1'b1;
          end else begin
            // C phase closes the (group, column) pair
            op_addc_o  <= 1'b1;
            op1_last_q <= j_last & g_last;
            cph_q      <= 1'b0;
            k_q        <= '0;
            if (j_last) begin
              j_q <= '0;
              if (g_last) state_q <= ST_DRAIN;
              else        grp_q   <= grp_q + 1'b1;
            end else begin
              j_q <= j_q + 1'b1;
            end
          end
        end
        ST_DRAIN: if (op2_last_q) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = done_q;
  assign mac_rd_o = (state_q == ST_RUN) && !cph_q;
  assign c_rd_o   = (state_q == ST_RUN) && cph_q;
  assign rd_grp_o = grp_q;
  assign rd_k_o   = k_q;
  assign rd_j_o   = j_q;
  assign m_cur_o  = m_q;
  assign p_cur_o  = p_q;

endmodule

// File: rtl/mma_pe.sv
module mma_pe #(
  parameter int DW    = 8,
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mac_i,
  input  logic             first_i,
  input  logic             addc_i,
  input  logic             lane_en_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [DW-1:0]    c_i,
  output logic             vld_o,
  output logic [ACC_W-1:0] res_o
);

  localparam int PW2 = 2 * DW;

  logic signed [PW2-1:0]   prod;
  logic signed [ACC_W-1:0] prod_x, c_x, acc_q;

  assign prod   = $signed(a_i) * $signed(b_i);
  assign prod_x = {{(ACC_W-PW2){prod[PW2-1]}}, prod};
  assign c_x    = {{(ACC_W-DW){c_i[DW-1]}}, c_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (mac_i) acc_q <= (first_i ? '0 : acc_q) + prod_x;
      if (addc_i) begin
        res_o <= acc_q + c_x;
        vld_o <= lane_en_i;
      end
    end
  end

endmodule

// File: rtl/mma_row_engine.sv
module mma_row_engine
  import mma_pkg::*;
#(
  parameter int NPE   = 4,
  parameter int M_MAX = 10,
  parameter int N_MAX = 8,
  parameter int P_MAX = 8,
  parameter int DW    = 8,
  localparam int ACC_W = 2 * DW + $clog2(N_MAX) + 1,
  localparam int MW    = $clog2(M_MAX + 1),
  localparam int NW    = $clog2(N_MAX + 1),
  localparam int PW    = $clog2(P_MAX + 1),
  localparam int GW    = clog1((M_MAX + NPE - 1) / NPE),
  localparam int KW    = clog1(N_MAX),
  localparam int JW    = clog1(P_MAX)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [MW-1:0]        m_i,
  input  logic [NW-1:0]        n_i,
  input  logic [PW-1:0]        p_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 mac_rd_o,
  output logic                 c_rd_o,
  output logic [GW-1:0]        rd_grp_o,
  output logic [KW-1:0]        rd_k_o,
  output logic [JW-1:0]        rd_j_o,
  input  logic [NPE*DW-1:0]    a_data_i,
  input  logic [DW-1:0]        b_data_i,
  input  logic [NPE*DW-1:0]    c_data_i,
  output logic [NPE-1:0]       res_valid_o,
  output logic [MW-1:0]        res_row_o,
  output logic [JW-1:0]        res_col_o,
  output logic [NPE*ACC_W-1:0] res_data_o
);

  logic          op_mac, op_first, op_addc;
  logic [GW-1:0] op_grp;
  logic [JW-1:0] op_j;
  logic [MW-1:0] m_cur;
  logic [PW-1:0] p_cur;

  mma_seq #(
    .NPE(NPE), .M_MAX(M_MAX), .N_MAX(N_MAX), .P_MAX(P_MAX)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .m_i        (m_i),
    .n_i        (n_i),
    .p_i        (p_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mac_rd_o   (mac_rd_o),
    .c_rd_o     (c_rd_o),
    .rd_grp_o   (rd_grp_o),
    .rd_k_o     (rd_k_o),
    .rd_j_o     (rd_j_o),
    .op_mac_o   (op_mac),
    .op_first_o (op_first),
    .op_addc_o  (op_addc),
    .op_grp_o   (op_grp),
    .op_j_o     (op_j),
    .m_cur_o    (m_cur),
    .p_cur_o    (p_cur)
  );

  for (genvar q = 0; q < NPE; q++) begin : g_lane
    logic lane_en;
    assign lane_en = (int'(op_grp) * NPE + q) < int'(m_cur);

    mma_pe #(.DW(DW), .ACC_W(ACC_W)) u_pe (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mac_i     (op_mac),
      .first_i   (op_first),
      .addc_i    (op_addc),
      .lane_en_i (lane_en),
      .a_i       (a_data_i[q*DW +: DW]),
      .b_i       (b_data_i),
      .c_i       (c_data_i[q*DW +: DW]),
      .vld_o     (res_valid_o[q]),
      .res_o     (res_data_o[q*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_row_o <= '0;
      res_col_o <= '0;
    end else if (op_addc) begin
      res_row_o <= MW'(int'(op_grp) * NPE);
      res_col_o <= op_j;
    end
  end

endmodule

// File: rtl/mma_row_engine_chk.sv
module mma_row_engine_chk #(
  parameter int NPE   = 4,
  parameter int M_MAX = 10,
  parameter int P_MAX = 8,
  parameter int JW    = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       busy_o,
  input logic                       done_o,
  input logic                       mac_rd_o,
  input logic                       c_rd_o,
  input logic [NPE-1:0]             res_valid_o,
  input logic [$clog2(M_MAX+1)-1:0] res_row_o,
  input logic [JW-1:0]              res_col_o,
  input logic [$clog2(M_MAX+1)-1:0] m_cur,
  input logic [$clog2(P_MAX+1)-1:0] p_cur
);

  logic [NPE-1:0] vld_inc;
  int             rows_left, lanes_exp;

  assign vld_inc   = res_valid_o + {{(NPE-1){1'b0}}, 1'b1};
  assign rows_left = int'(m_cur) - int'(res_row_o);
  assign lanes_exp = (rows_left > NPE) ? NPE : rows_left;

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r6_rd_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mac_rd_o && c_rd_o));

  a_r6_rd_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_rd_o || c_rd_o) |-> busy_o);

  a_r5_lane_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|res_valid_o) |-> ((res_valid_o & vld_inc) == '0));

  a_r5_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|res_valid_o) |-> ($countones(res_valid_o) == lanes_exp));

  a_r3_col_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|res_valid_o) |-> (int'(res_col_o) < int'(p_cur)));

  a_r8_dims_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || ($stable(m_cur) && $stable(p_cur))));

endmodule

bind mma_row_engine mma_row_engine_chk #(
  .NPE(NPE), .M_MAX(M_MAX), .P_MAX(P_MAX), .JW(JW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mac_rd_o    (mac_rd_o),
  .c_rd_o      (c_rd_o),
  .res_valid_o (res_valid_o),
  .res_row_o   (res_row_o),
  .res_col_o   (res_col_o),
  .m_cur       (m_cur),
  .p_cur       (p_cur)
);

// File: tb/mma_row_engine_tb_top.sv
module mma_row_engine_tb_top;

  localparam int NPE   = 4;
  localparam int M_MAX = 10;
  localparam int N_MAX = 8;
  localparam int P_MAX = 8;
  localparam int DW    = 8;
  localparam int ACC_W = 2 * DW + $clog2(N_MAX) + 1;
  localparam int MW    = $clog2(M_MAX + 1);
  localparam int NW    = $clog2(N_MAX + 1);
  localparam int PW    = $clog2(P_MAX + 1);
  localparam int GW    = 2;
  localparam int KW    = 3;
  localparam int JW    = 3;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 start_i = 1'b0;
  logic [MW-1:0]        m_i = '0;
  logic [NW-1:0]        n_i = '0;
  logic [PW-1:0]        p_i = '0;
  logic                 busy_o, done_o, mac_rd_o, c_rd_o;
  logic [GW-1:0]        rd_grp_o;
  logic [KW-1:0]        rd_k_o;
  logic [JW-1:0]        rd_j_o;
  logic [NPE*DW-1:0]    a_data_i = '0;
  logic [DW-1:0]        b_data_i = '0;
  logic [NPE*DW-1:0]    c_data_i = '0;
  logic [NPE-1:0]       res_valid_o;
  logic [MW-1:0]        res_row_o;
  logic [JW-1:0]        res_col_o;
  logic [NPE*ACC_W-1:0] res_data_o;

  mma_row_engine #(
    .NPE(NPE), .M_MAX(M_MAX), .N_MAX(N_MAX), .P_MAX(P_MAX), .DW(DW)
  ) dut_i (.*);

  always #5 clk_i = ~clk_i;

  logic signed [DW-1:0] am [M_MAX][N_MAX];
  logic signed [DW-1:0] bm [N_MAX][P_MAX];
  logic signed [DW-1:0] cm [M_MAX][P_MAX];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cur_m = 1, cur_n = 1, cur_p = 1;
  int start_cyc = 0, out_idx = 0, last_out_cyc = 0, done_cnt = 0, done_cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // memory model, one-cycle read latency (R6)
  always @(posedge clk_i) begin
    if (mac_rd_o) begin
      for (int q = 0; q < NPE; q++) begin
        int row;
        row = int'(rd_grp_o) * NPE + q;
        a_data_i[q*DW +: DW] <= (row < M_MAX) ? am[row][rd_k_o] : '0;
      end
      b_data_i <= bm[rd_k_o][rd_j_o];
    end
    if (c_rd_o) begin
      for (int q = 0; q < NPE; q++) begin
        int row;
        row = int'(rd_grp_o) * NPE + q;
        c_data_i[q*DW +: DW] <= (row < M_MAX) ? cm[row][rd_j_o] : '0;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  function automatic longint exp_res(input int row, input int j);
    longint s = 0;
    for (int k = 0; k < cur_n; k++) s += longint'(am[row][k]) * longint'(bm[k][j]);
    return s + longint'(cm[row][j]);
  endfunction

  // result monitor
  always @(negedge clk_i) begin
    if (rst_ni && |res_valid_o) begin
      int g, j;
      g = out_idx / cur_p;
      j = out_idx % cur_p;
      chk(int'(res_row_o) == g * NPE, "R3", "row base", res_row_o, g * NPE);
      chk(int'(res_col_o) == j, "R3", "column", res_col_o, j);
      chk(cyc == start_cyc + 3 + cur_n + out_idx * (cur_n + 1), "R4", "beat cycle",
          cyc, start_cyc + 3 + cur_n + out_idx * (cur_n + 1));
      for (int q = 0; q < NPE; q++) begin
        int  row;
        bit  ev;
        row = g * NPE + q;
        ev  = row < cur_m;
        chk(res_valid_o[q] == ev, "R5", "lane valid", res_valid_o[q], ev);
        if (ev)
          chk(longint'($signed(res_data_o[q*ACC_W +: ACC_W])) == exp_res(row, j), "R2",
              "result", longint'($signed(res_data_o[q*ACC_W +: ACC_W])), exp_res(row, j));
      end
      out_idx++;
      last_out_cyc = cyc;
    end
    if (rst_ni && done_o) begin
      chk(cyc == last_out_cyc + 1, "R7", "done cycle", cyc, last_out_cyc + 1);
      chk(!busy_o, "R7", "busy at done", busy_o, 0);
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic fill(input int mode);
    for (int r = 0; r < M_MAX; r++)
      for (int k = 0; k < N_MAX; k++)
        am[r][k] = (mode == 0) ? DW'($urandom) : (mode == 1) ? -8'sd128 : 8'sd127;
    for (int k = 0; k < N_MAX; k++)
      for (int j = 0; j < P_MAX; j++)
        bm[k][j] = (mode == 0) ? DW'($urandom) : -8'sd128;
    for (int r = 0; r < M_MAX; r++)
      for (int j = 0; j < P_MAX; j++)
        cm[r][j] = (mode == 0) ? DW'($urandom) : (mode == 1) ? -8'sd128 : 8'sd127;
  endtask

  task automatic pulse_start(input int m, input int n, input int p);
    @(negedge clk_i);
    start_i = 1'b1;
    m_i = MW'(m);
    n_i = NW'(n);
    p_i = PW'(p);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_job(input int m, input int n, input int p, input string tag);
    int g, wait_c;
    cur_m = m; cur_n = n; cur_p = p;
    out_idx = 0; done_cnt = 0;
    start_cyc = cyc + 1;
    pulse_start(m, n, p);
    wait_c = 0;
    while (done_cnt == 0 && wait_c < 2000) begin
      @(negedge clk_i);
      wait_c++;
    end
    g = (m + NPE - 1) / NPE;
    chk(out_idx == g * p, "R3", {tag, " beat count"}, out_idx, g * p);
    chk(done_cnt == 1, "R7", {tag, " done seen"}, done_cnt, 1);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o, "R1", "busy/done after reset", {busy_o, done_o}, 0);
    chk(!mac_rd_o && !c_rd_o, "R1", "strobes after reset", {mac_rd_o, c_rd_o}, 0);
    chk(res_valid_o == '0, "R1", "valid after reset", res_valid_o, 0);
  endtask

  task automatic t_basic();
    fill(0);
    run_job(4, 3, 2, "R2 full group");
    run_job(5, 4, 3, "R5 partial group");
    run_job(1, 1, 1, "R4 minimal");
    run_job(7, 2, 5, "R3 two groups");
  endtask

  task automatic t_max();
    fill(0);
    run_job(M_MAX, N_MAX, P_MAX, "R2 full size");
  endtask

  task automatic t_extremes();
    fill(1);
    run_job(4, N_MAX, 2, "R2 negative extreme");
    fill(2);
    run_job(6, N_MAX, 1, "R2 mixed extreme");
  endtask

  task automatic t_single_group();
    fill(0);
    run_job(3, 5, 4, "R10 single group");
    chk(done_cyc == start_cyc + 1 + 4 * (5 + 1) + 2, "R10", "done timing",
        done_cyc, start_cyc + 1 + 4 * 6 + 2);
  endtask

  task automatic t_start_busy();
    int wait_c;
    fill(0);
    cur_m = 5; cur_n = 4; cur_p = 3;
    out_idx = 0; done_cnt = 0;
    start_cyc = cyc + 1;
    pulse_start(5, 4, 3);
    repeat (6) @(negedge clk_i);
    chk(busy_o, "R8", "busy mid job", busy_o, 1);
    pulse_start(1, 1, 1);
    wait_c = 0;
    while (done_cnt == 0 && wait_c < 2000) begin
      @(negedge clk_i);
      wait_c++;
    end
    repeat (20) @(negedge clk_i);
    chk(out_idx == 6, "R8", "beats after ignored start", out_idx, 6);
    chk(done_cnt == 1, "R8", "single done", done_cnt, 1);
    chk(!busy_o, "R8", "idle afterwards", busy_o, 0);
  endtask

  task automatic t_bad_dims();
    int bad [5][3] = '{'{0, 2, 2}, '{2, 0, 2}, '{2, 2, 0}, '{11, 2, 2}, '{2, 9, 2}};
    for (int i = 0; i < 5; i++) begin
      out_idx = 0; done_cnt = 0;
      pulse_start(bad[i][0], bad[i][1], bad[i][2]);
      chk(!busy_o, "R9", "busy after illegal start", busy_o, 0);
      repeat (20) @(negedge clk_i);
      chk(out_idx == 0 && done_cnt == 0, "R9", "no activity", out_idx + done_cnt, 0);
    end
  endtask

  initial begin
    fill(0);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_basic();
    t_max();
    t_extremes();
    t_single_group();
    t_start_busy();
    t_bad_dims();
    summary();
    $finish;
  end

endmodule